// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates a bank of maskable interrupt sources for a processor core and keeps track of which priority levels are currently being serviced. Each source has its own configuration entry with a 3-bit priority level (0 is the most urgent, 7 the least) and a mask bit. A request is captured on its rising edge into a pending flag. Every cycle the controller picks the best unmasked pending source. That source is acknowledged when nothing is in service, or when its level is strictly more urgent than the level currently at the top of service.

Acknowledged levels are pushed onto an in-service stack. A return strobe from the core pops the top entry, and the interrupted service becomes current again. A separate non-maskable request is also pushed onto the stack. While it sits on top, no maskable source is acknowledged and maskable requests simply stay pending. The core uses the one-hot or indexed acknowledge to dispatch, and it issues the return strobe when each handler ends.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every source is masked with level 7, nothing is pending, the in-service stack is empty, and ack_valid, nmi_ack, svc_active and nmi_busy are 0.
- R2: A source becomes pending on a low-to-high transition of its request line. A line held high does not set the flag again after it has been acknowledged.
- R3: A masked source keeps its pending flag but is never acknowledged. It is acknowledged once it is unmasked, if it then wins.
- R4: Among unmasked pending sources the lowest level number wins. On a tie the lowest source index wins.
- R5: With a maskable entry on top of the stack, a candidate is acknowledged only if its level is numerically lower than that entry's level. Otherwise it stays pending. With an empty stack any winner is acknowledged.
- R6: An acknowledge is a one-cycle ack_valid with ack_onehot having exactly bit ack_idx set. It appears on the clock edge after the edge that latched the request, and the source's pending flag is cleared on that same edge.
- R7: A return strobe with a non-empty stack removes the top entry. svc_level then reports the level of the entry below it, which is the resumed service.
- R8: A return strobe while the stack is empty is ignored: svc_active stays 0 unless something is pushed in that same cycle.
- R9: A rising edge on nmi_req gives a one-cycle nmi_ack and pushes a non-maskable entry (nmi_busy=1). Until its return strobe, no maskable acknowledge is issued.
- R10: When a return strobe and an arbitration fall in the same cycle, the pop happens first. The candidate is then compared with the entry that becomes the new top.
- R11: A configuration write (cfg_we with cfg_idx, cfg_level, cfg_mask) is registered and first affects arbitration on the following cycle.
- R12: When a non-maskable acknowledge and a maskable acknowledge are possible in the same cycle, only nmi_ack is issued, and the maskable request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_SRC | Maskable request lines, edge-captured |
| nmi_req | input | 1 | Non-maskable request, edge-captured |
| eoi | input | 1 | Return-from-service strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | IDX_W | Source selected by the write |
| cfg_level | input | 3 | Priority level written |
| cfg_mask | input | 1 | Mask bit written (1 = masked) |
| ack_valid | output | 1 | Maskable acknowledge pulse |
| ack_onehot | output | NUM_SRC | One-hot acknowledged source |
| ack_idx | output | IDX_W | Index of acknowledged source |
| nmi_ack | output | 1 | Non-maskable acknowledge pulse |
| svc_active | output | 1 | In-service stack is not empty |
| nmi_busy | output | 1 | Top of stack is the non-maskable entry |
| svc_level | output | 3 | Level of the top maskable entry (7 when empty) |

## Verification
The interesting overlap is a return strobe that arrives in the same cycle as an arbitration decision. The pop must be applied before the preemption comparison, so a pending request that had been blocked can be acknowledged in the very cycle that unblocks it. The bench provokes this directly by sending a strobe while a same-level request is waiting, and it also hits it in random traffic where strobes, request edges and non-maskable pulses overlap freely. A cycle-level reference model in the bench decides the pop-then-compare outcome and is compared with the acknowledge outputs and stack state after every edge.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef struct packed {
    logic             is_nmi;
    logic [LVL_W-1:0] lvl;
  } svc_ent_t;

  // a outranks b when its level number is strictly smaller
  function automatic logic lvl_outranks(input logic [LVL_W-1:0] a,
                                        input logic [LVL_W-1:0] b);
    return a < b;
  endfunction
endpackage

// File: rtl/nic_src_bank.sv
module nic_src_bank
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       irq_req,
  input  logic [NUM_SRC-1:0]       grant_oh,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [LVL_W-1:0]         cfg_level,
  input  logic                     cfg_mask,
  output logic [NUM_SRC-1:0]       pend,
  output logic [NUM_SRC-1:0]       mask,
  output logic [NUM_SRC*LVL_W-1:0] lvl_flat
);
  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] req_rise;

  assign req_rise = irq_req & ~req_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [LVL_W-1:0] lvl_r;
    logic             sel;
    assign sel = cfg_we && (cfg_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_r   <= '1;
        mask[i] <= 1'b1;
        pend[i] <= 1'b0;
        req_q[i] <= 1'b0;
      end else begin
        req_q[i] <= irq_req[i];
        pend[i]  <= (pend[i] & ~grant_oh[i]) | req_rise[i];
        if (sel) begin
          lvl_r   <= cfg_level;
          mask[i] <= cfg_mask;
        end
      end
    end

    assign lvl_flat[i*LVL_W +: LVL_W] = lvl_r;
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC-1:0]       mask,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic                     win_valid,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] hit [NUM_LVL];

  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign elig = pend & ~mask;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
      assign hit[l][i] = elig[i] && (lvl_flat[i*LVL_W +: LVL_W] == LVL_W'(l));
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '1;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (|hit[l]) begin
        win_valid = 1'b1;
        win_lvl   = LVL_W'(l);
        win_idx   = lowest_set(hit[l]);
      end
    end
  end
endmodule

// File: rtl/nic_svc_stack.sv
module nic_svc_stack
  import nic_pkg::*;
#(
  parameter int DEPTH = NUM_LVL + 1,
  parameter int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop_req,
  input  logic            push,
  input  svc_ent_t        push_ent,
  output logic [SP_W-1:0] sp,
  output svc_ent_t        top_ent,
  output logic            post_valid,
  output svc_ent_t        post_ent
);
  svc_ent_t        mem [DEPTH];
  logic            pop_ok;
  logic [SP_W-1:0] sp_post;

  always_comb begin
    pop_ok     = pop_req && (sp != '0);
    sp_post    = sp - SP_W'(pop_ok);
    post_valid = (sp_post != '0);
    post_ent   = post_valid ? mem[sp_post - SP_W'(1)] : '0;
    top_ent    = (sp != '0) ? mem[sp - SP_W'(1)] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= '0;
    else if (push && sp_post < SP_W'(DEPTH)) sp <= sp_post + SP_W'(1);
    else sp <= sp_post;
  end

  always_ff @(posedge clk) begin
    if (push && sp_post < SP_W'(DEPTH)) mem[sp_post] <= push_ent;
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = $clog2(NUM_SRC),
  parameter int DEPTH   = NUM_LVL + 1,
  parameter int SP_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               nmi_req,
  input  logic               eoi,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [LVL_W-1:0]   cfg_level,
  input  logic               cfg_mask,
  output logic               ack_valid,
  output logic [NUM_SRC-1:0] ack_onehot,
  output logic [IDX_W-1:0]   ack_idx,
  output logic               nmi_ack,
  output logic               svc_active,
  output logic               nmi_busy,
  output logic [LVL_W-1:0]   svc_level
);
  logic [NUM_SRC-1:0]       pend, mask, grant_oh;
  logic [NUM_SRC*LVL_W-1:0] lvl_flat;
  logic                     win_valid;
  logic [IDX_W-1:0]         win_idx;
  logic [LVL_W-1:0]         win_lvl;
  logic [SP_W-1:0]          sp;
  svc_ent_t                 top_ent, post_ent, push_ent;
  logic                     post_valid, push;
  logic                     nmi_q, nmi_pend;
  // named internal events
  logic                     nmi_on_top_post;
  logic                     nmi_take;
  logic                     mask_take;

  nic_src_bank #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .grant_oh(grant_oh),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_level(cfg_level), .cfg_mask(cfg_mask),
    .pend(pend), .mask(mask), .lvl_flat(lvl_flat)
  );

  nic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .pend(pend), .mask(mask), .lvl_flat(lvl_flat),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  nic_svc_stack #(.DEPTH(DEPTH), .SP_W(SP_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .pop_req(eoi), .push(push), .push_ent(push_ent),
    .sp(sp), .top_ent(top_ent), .post_valid(post_valid), .post_ent(post_ent)
  );

  always_comb begin
    nmi_on_top_post = post_valid && post_ent.is_nmi;
    nmi_take        = nmi_pend && !nmi_on_top_post;
    mask_take       = win_valid && !nmi_on_top_post && !nmi_take &&
                      (!post_valid || lvl_outranks(win_lvl, post_ent.lvl));
    grant_oh        = mask_take ? (NUM_SRC'(1) << win_idx) : '0;
    push            = nmi_take || mask_take;
    push_ent.is_nmi = nmi_take;
    push_ent.lvl    = nmi_take ? '0 : win_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q      <= 1'b0;
      nmi_pend   <= 1'b0;
      ack_valid  <= 1'b0;
      ack_onehot <= '0;
      ack_idx    <= '0;
      nmi_ack    <= 1'b0;
    end else begin
      nmi_q      <= nmi_req;
      nmi_pend   <= (nmi_pend && !nmi_take) || (nmi_req && !nmi_q);
      ack_valid  <= mask_take;
      ack_onehot <= grant_oh;
      ack_idx    <= mask_take ? win_idx : '0;
      nmi_ack    <= nmi_take;
    end
  end

  assign svc_active = (sp != '0);
  assign nmi_busy   = svc_active && top_ent.is_nmi;
  assign svc_level  = svc_active ? top_ent.lvl : '1;
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4,
  parameter int DEPTH   = 9,
  parameter int SP_W    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               eoi,
  input logic               ack_valid,
  input logic [NUM_SRC-1:0] ack_onehot,
  input logic [IDX_W-1:0]   ack_idx,
  input logic               nmi_ack,
  input logic               nmi_busy,
  input logic               svc_active,
  input logic [2:0]         svc_level,
  input logic [SP_W-1:0]    sp
);
  AST_ACK_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $countones(ack_onehot) == 1); // R6
  AST_ACK_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ack_onehot[ack_idx]); // R6
  AST_IDLE_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |-> ack_onehot == '0); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sp) <= DEPTH); // R7
  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_active && eoi) |=> int'(sp) == int'($past(sp)) - 1 + int'(ack_valid || nmi_ack)); // R7
  AST_EMPTY_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_active && eoi) |=> int'(sp) == int'(ack_valid || nmi_ack)); // R8
  AST_NMI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_busy && !eoi) |=> !ack_valid); // R9
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_active && !nmi_busy && !eoi) |=> (!ack_valid || svc_level < $past(svc_level))); // R5
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |-> !ack_valid); // R12
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DEPTH(DEPTH), .SP_W(SP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .eoi(eoi), .ack_valid(ack_valid),
  .ack_onehot(ack_onehot), .ack_idx(ack_idx), .nmi_ack(nmi_ack),
  .nmi_busy(nmi_busy), .svc_active(svc_active), .svc_level(svc_level), .sp(sp)
);

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam time HALF = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic          nmi_req = 1'b0, eoi = 1'b0, cfg_we = 1'b0, cfg_mask = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [2:0]    cfg_level = '0;
  logic          ack_valid, nmi_ack, svc_active, nmi_busy;
  logic [N-1:0]  ack_onehot;
  logic [IW-1:0] ack_idx;
  logic [2:0]    svc_level;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(HALF) clk = ~clk;

  nest_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req), .eoi(eoi),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_level(cfg_level), .cfg_mask(cfg_mask),
    .ack_valid(ack_valid), .ack_onehot(ack_onehot), .ack_idx(ack_idx),
    .nmi_ack(nmi_ack), .svc_active(svc_active), .nmi_busy(nmi_busy), .svc_level(svc_level)
  );

  // reference model state
  int m_lvl [N];
  bit m_msk [N];
  bit m_pnd [N];
  bit m_rq  [N];
  bit m_nq, m_npnd;
  int m_stk [$];   // -1 marks a non-maskable entry
  bit e_ack, e_nack;
  int e_idx;

  function automatic int best_src();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m_pnd[i] && !m_msk[i] && (b < 0 || m_lvl[i] < m_lvl[b])) b = i;
    return b;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin
      m_lvl[i] = 7; m_msk[i] = 1; m_pnd[i] = 0; m_rq[i] = 0;
    end
    m_nq = 0; m_npnd = 0; m_stk.delete();
    e_ack = 0; e_nack = 0; e_idx = 0;
  endfunction

  function automatic void model_edge();
    int b;
    bit nmi_top;
    e_ack = 0; e_nack = 0; e_idx = 0;
    if (eoi && m_stk.size() > 0) void'(m_stk.pop_back());
    nmi_top = (m_stk.size() > 0) && (m_stk[$] < 0);
    if (m_npnd && !nmi_top) begin
      m_stk.push_back(-1); e_nack = 1; m_npnd = 0;
    end else if (!nmi_top) begin
      b = best_src();
      if (b >= 0 && (m_stk.size() == 0 || m_lvl[b] < m_stk[$])) begin
        m_stk.push_back(m_lvl[b]); e_ack = 1; e_idx = b; m_pnd[b] = 0;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (irq_req[i] && !m_rq[i]) m_pnd[i] = 1;
      m_rq[i] = irq_req[i];
    end
    if (nmi_req && !m_nq) m_npnd = 1;
    m_nq = nmi_req;
    if (cfg_we) begin
      m_lvl[cfg_idx] = int'(cfg_level);
      m_msk[cfg_idx] = cfg_mask;
    end
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    bit act_e = m_stk.size() > 0;
    chk("R6 ack_valid vs model", int'(ack_valid), int'(e_ack));
    if (e_ack) begin
      chk("R4 ack_idx vs model", int'(ack_idx), e_idx);
      chk("R6 ack_onehot vs model", int'(ack_onehot), 1 << e_idx);
    end
    chk("R9 nmi_ack vs model", int'(nmi_ack), int'(e_nack));
    chk("R7 svc_active vs model", int'(svc_active), int'(act_e));
    if (act_e) begin
      chk("R9 nmi_busy vs model", int'(nmi_busy), int'(m_stk[$] < 0));
      if (m_stk[$] >= 0) chk("R7 svc_level vs model", int'(svc_level), m_stk[$]);
    end
  endtask

  // inputs are already set; run one edge and compare at the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_model();
    cfg_we = 0; eoi = 0;
  endtask

  task automatic cfg(input int idx, input int lv, input bit mk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_level = 3'(lv); cfg_mask = mk;
    step();
  endtask

  task automatic ret();
    eoi = 1; step();
  endtask

  initial begin
    #(HALF * 2 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 ack_valid after reset", int'(ack_valid), 0);
    chk("R1 svc_active after reset", int'(svc_active), 0);
    chk("R1 nmi_busy after reset", int'(nmi_busy), 0);
    chk("R1 nmi_ack after reset", int'(nmi_ack), 0);

    // R1/R3: default mask holds off source 3
    irq_req[3] = 1; step(); step(); step();
    chk("R3 masked source not acked", int'(ack_valid), 0);
    cfg(3, 5, 0);
    chk("R11 write not yet effective", int'(ack_valid), 0);
    step();
    chk("R11 ack after write", int'(ack_valid), 1);
    chk("R3 ack index 3", int'(ack_idx), 3);
    chk("R6 onehot bit 3", int'(ack_onehot), 1 << 3);
    step();
    chk("R6 ack lasts one cycle", int'(ack_valid), 0);
    chk("R2 held line not re-pended", int'(ack_valid), 0);
    chk("R7 level 5 in service", int'(svc_level), 5);

    cfg(1, 5, 0); cfg(9, 2, 0); cfg(12, 2, 0);
    irq_req[3] = 0;
    irq_req[1] = 1; step(); step();
    chk("R5 equal level stays pending", int'(ack_valid), 0);
    irq_req[9] = 1; irq_req[12] = 1; step(); step();
    chk("R4 tie lowest index wins", int'(ack_idx), 9);
    chk("R5 strictly higher preempts", int'(svc_level), 2);
    step();
    chk("R5 same level 12 waits", int'(ack_valid), 0);
    ret();
    chk("R10 pop then ack same cycle", int'(ack_valid), 1);
    chk("R10 ack index 12", int'(ack_idx), 12);
    ret();
    chk("R7 resumed level 5", int'(svc_level), 5);
    chk("R5 level 5 request still waits", int'(ack_valid), 0);
    ret();
    chk("R10 empty after pop acks 1", int'(ack_idx), 1);
    ret();
    chk("R7 stack empty", int'(svc_active), 0);
    ret();
    chk("R8 empty return ignored", int'(svc_active), 0);
    irq_req = '0; step();

    // R12 and R9
    irq_req[9] = 1; nmi_req = 1; step(); step();
    chk("R12 nmi acked", int'(nmi_ack), 1);
    chk("R12 maskable held back", int'(ack_valid), 0);
    chk("R9 nmi busy", int'(nmi_busy), 1);
    step();
    chk("R9 no maskable under nmi", int'(ack_valid), 0);
    nmi_req = 0; ret();
    chk("R9 maskable after nmi return", int'(ack_valid), 1);
    ret();
    irq_req = '0; step();

    // R3: pending survives masking
    cfg(12, 2, 1);
    irq_req[12] = 1; step(); step(); step();
    chk("R3 masked keeps waiting", int'(ack_valid), 0);
    cfg(12, 2, 0); step();
    chk("R3 ack once unmasked", int'(ack_idx), 12);
    ret(); irq_req = '0; step();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      irq_req = irq_req ^ (N'($urandom) & N'($urandom) & N'($urandom));
      if ($urandom_range(31) == 0) nmi_req = ~nmi_req;
      eoi = ($urandom_range(3) == 0);
      if ($urandom_range(7) == 0) begin
        cfg_we = 1; cfg_idx = IW'($urandom); cfg_level = 3'($urandom);
        cfg_mask = ($urandom_range(3) == 0);
      end
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule